// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer Counter

This block is a general-purpose timer made of two counting stages. A prescaler divides the clock by its programmed value plus one. The main counter advances once per prescaler tick. It counts either upward from zero to a programmable reload value, or downward from that reload value to zero. Each time the counter wraps, the block emits a one-cycle update pulse. The update pulse therefore repeats at the clock rate divided by (prescaler+1) and then by (reload+1).

Software drives the block through a small register port: a control word, the prescaler, the reload value and the live count. The prescaler value is always buffered and reaches the active stage only at an update event. The reload value is either buffered in the same way or written straight into the active register, depending on a preload-enable bit. A self-clearing force bit in the control word makes an update event at once: the buffered values move into the active registers and both counters restart.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset, count_o and update_o are 0, and every register address reads 0.
- R2: Register map. Address 0 is control: bit 0 enable, bit 1 count down (1) or up (0), bit 2 preload enable, bit 3 force update. Address 1 is the prescaler, address 2 is the reload value and address 3 is the count. Reads return the last written prescaler, reload and count values. Bit 3 of control always reads 0.
- R3: While enabled with active prescaler P and reload A, update events repeat every (P+1)*(A+1) clock cycles.
- R4: Counting up, a tick when the count is at or above the active reload sets the count to 0. Counting down, a tick at 0 loads the reload value. Either wrap raises update_o for one cycle, in the same cycle that count_o shows the wrapped value.
- R5: With preload enable set, a reload write only changes the buffer. The active reload changes at the next update event.
- R6: With preload enable clear, a reload write becomes the active reload on the next clock edge.
- R7: A prescaler write changes the division ratio only from the next update event on.
- R8: Writing control with bit 3 set makes an update event on that edge, even when the timer is disabled. The buffered values are transferred, the count becomes 0 (up) or the reload value (down, using the direction bit of the same write), and update_o pulses for one cycle.
- R9: Every update event, natural or forced, restarts the prescaler count from zero.
- R10: With enable clear, the count holds its value and no update occurs. A write to address 3 loads the count directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| count_o | output | CNT_W | Current count |
| update_o | output | 1 | One-cycle update event pulse |

## Verification
A table of prescaler, reload and direction settings measures the cycle gap between update pulses. The table includes unit division in both stages, division only in the prescaler, division only in the counter, and both directions. This separates errors in the prescaler wrap, the counter wrap and the down-count reload value. Directed sequences write the reload or prescaler mid-period with preload on and off. They fire a forced update part-way through a prescale interval and load a count above the reload value. The resulting gaps show whether a value took effect at once, at the next update event, or never.

// File: rtl/prt_pkg.sv
package prt_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_PSC    = 2'd1,
    ADDR_RELOAD = 2'd2,
    ADDR_COUNT  = 2'd3
  } prt_addr_e;

  localparam int CTL_EN    = 0;
  localparam int CTL_DOWN  = 1;
  localparam int CTL_PRE   = 2;
  localparam int CTL_FORCE = 3;

  typedef struct packed {
    logic preload;
    logic down;
    logic en;
  } prt_ctrl_t;

endpackage

// File: rtl/prt_rst_sync.sv
module prt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/prt_regs.sv
module prt_regs
  import prt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0]  cnt_i,
  output prt_ctrl_t         ctrl_o,
  output logic [PSC_W-1:0]  psc_buf_o,
  output logic [CNT_W-1:0]  arr_buf_o,
  output logic              force_o,
  output logic              force_down_o,
  output logic              arr_wr_o,
  output logic              cnt_wr_o,
  output logic [CNT_W-1:0]  wdata_o,
  output logic [DATA_W-1:0] reg_rdata_o
);
  prt_addr_e addr;
  logic wr_ctrl, wr_psc, wr_arr, wr_cnt;

  prt_ctrl_t        ctrl_q, ctrl_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [CNT_W-1:0] arr_q, arr_d;

  assign addr    = prt_addr_e'(reg_addr);
  assign wr_ctrl = reg_we && (addr == ADDR_CTRL);
  assign wr_psc  = reg_we && (addr == ADDR_PSC);
  assign wr_arr  = reg_we && (addr == ADDR_RELOAD);
  assign wr_cnt  = reg_we && (addr == ADDR_COUNT);

  // next-state
  always_comb begin
    ctrl_d = ctrl_q;
    psc_d  = psc_q;
    arr_d  = arr_q;
    if (wr_ctrl) begin
      ctrl_d.en      = reg_wdata[CTL_EN];
      ctrl_d.down    = reg_wdata[CTL_DOWN];
      ctrl_d.preload = reg_wdata[CTL_PRE];
    end
    if (wr_psc) psc_d = reg_wdata[PSC_W-1:0];
    if (wr_arr) arr_d = reg_wdata[CNT_W-1:0];
  end

  // registers with explicit load enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      arr_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_psc)  psc_q  <= psc_d;
      if (wr_arr)  arr_q  <= arr_d;
    end
  end

  assign ctrl_o       = ctrl_q;
  assign psc_buf_o    = psc_q;
  assign arr_buf_o    = arr_q;
  assign force_o      = wr_ctrl && reg_wdata[CTL_FORCE];
  assign force_down_o = reg_wdata[CTL_DOWN];
  assign arr_wr_o     = wr_arr;
  assign cnt_wr_o     = wr_cnt;
  assign wdata_o      = reg_wdata[CNT_W-1:0];

  // read path, zero-extended to the port width
  logic [DATA_W-1:0] psc_rd, arr_rd, cnt_rd, ctl_rd;

  generate
    if (PSC_W < DATA_W) begin : g_psc_pad
      assign psc_rd = {{(DATA_W-PSC_W){1'b0}}, psc_q};
    end else begin : g_psc_full
      assign psc_rd = psc_q;
    end
    if (CNT_W < DATA_W) begin : g_cnt_pad
      assign arr_rd = {{(DATA_W-CNT_W){1'b0}}, arr_q};
      assign cnt_rd = {{(DATA_W-CNT_W){1'b0}}, cnt_i};
    end else begin : g_cnt_full
      assign arr_rd = arr_q;
      assign cnt_rd = cnt_i;
    end
  endgenerate

  assign ctl_rd = {{(DATA_W-3){1'b0}}, ctrl_q.preload, ctrl_q.down, ctrl_q.en};

  always_comb begin
    unique case (addr)
      ADDR_CTRL:   reg_rdata_o = ctl_rd;
      ADDR_PSC:    reg_rdata_o = psc_rd;
      ADDR_RELOAD: reg_rdata_o = arr_rd;
      default:     reg_rdata_o = cnt_rd;
    endcase
  end
endmodule

// File: rtl/prt_prescaler.sv
module prt_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             upd_i,
  input  logic             force_i,
  input  logic [PSC_W-1:0] psc_buf_i,
  output logic             tick_o,
  output logic [PSC_W-1:0] psc_cnt_o
);
  logic [PSC_W-1:0] div_q, div_d;
  logic [PSC_W-1:0] pcnt_q, pcnt_d;
  logic             pcnt_en;

  assign tick_o  = run_i && (pcnt_q == div_q);
  assign pcnt_en = run_i || force_i;

  always_comb begin
    div_d  = upd_i ? psc_buf_i : div_q;
    pcnt_d = pcnt_q;
    if (force_i)     pcnt_d = '0;
    else if (tick_o) pcnt_d = '0;
    else if (run_i)  pcnt_d = pcnt_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      pcnt_q <= '0;
    end else begin
      if (upd_i)   div_q  <= div_d;
      if (pcnt_en) pcnt_q <= pcnt_d;
    end
  end

  assign psc_cnt_o = pcnt_q;
endmodule

// File: rtl/prt_counter.sv
module prt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             down_i,
  input  logic             force_i,
  input  logic             force_down_i,
  input  logic             preload_i,
  input  logic             arr_wr_i,
  input  logic [CNT_W-1:0] arr_buf_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] arr_act_o,
  output logic             upd_evt_o,
  output logic             update_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             upd_q;
  logic             at_top, at_zero, wrap, upd_evt, act_en;

  assign at_top  = (cnt_q >= act_q);
  assign at_zero = (cnt_q == '0);
  assign wrap    = tick_i && !cnt_wr_i && (down_i ? at_zero : at_top);
  assign upd_evt = force_i || wrap;
  assign act_en  = upd_evt || (arr_wr_i && !preload_i);

  always_comb begin
    // a direct reload write wins over a transfer in the same cycle
    if (arr_wr_i && !preload_i) act_d = wdata_i;
    else if (upd_evt)           act_d = arr_buf_i;
    else                        act_d = act_q;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (force_i)       cnt_d = force_down_i ? act_d : '0;
    else if (cnt_wr_i) cnt_d = wdata_i;
    else if (wrap)     cnt_d = down_i ? act_d : '0;
    else if (tick_i)   cnt_d = down_i ? cnt_q - CNT_W'(1) : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
      upd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (act_en) act_q <= act_d;
      upd_q <= upd_evt;
    end
  end

  assign cnt_o     = cnt_q;
  assign arr_act_o = act_q;
  assign upd_evt_o = upd_evt;
  assign update_o  = upd_q;
endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer
  import prt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W     = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [CNT_W-1:0]  count_o,
  output logic              update_o
);
  logic             rst_sync_n;
  prt_ctrl_t        ctrl_q;
  logic [PSC_W-1:0] psc_buf;
  logic [CNT_W-1:0] arr_buf, arr_act, wdata_c, cnt;
  logic             force_upd, force_down, arr_wr, cnt_wr;
  logic             tick, upd_evt;
  logic [PSC_W-1:0] psc_cnt;

  prt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  prt_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .cnt_i        (cnt),
    .ctrl_o       (ctrl_q),
    .psc_buf_o    (psc_buf),
    .arr_buf_o    (arr_buf),
    .force_o      (force_upd),
    .force_down_o (force_down),
    .arr_wr_o     (arr_wr),
    .cnt_wr_o     (cnt_wr),
    .wdata_o      (wdata_c),
    .reg_rdata_o  (reg_rdata)
  );

  prt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run_i     (ctrl_q.en),
    .upd_i     (upd_evt),
    .force_i   (force_upd),
    .psc_buf_i (psc_buf),
    .tick_o    (tick),
    .psc_cnt_o (psc_cnt)
  );

  prt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .tick_i       (tick),
    .down_i       (ctrl_q.down),
    .force_i      (force_upd),
    .force_down_i (force_down),
    .preload_i    (ctrl_q.preload),
    .arr_wr_i     (arr_wr),
    .arr_buf_i    (arr_buf),
    .cnt_wr_i     (cnt_wr),
    .wdata_i      (wdata_c),
    .cnt_o        (cnt),
    .arr_act_o    (arr_act),
    .upd_evt_o    (upd_evt),
    .update_o     (update_o)
  );

  assign count_o = cnt;
endmodule

// File: rtl/prt_checker.sv
module prt_checker
  import prt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input prt_ctrl_t         ctrl,
  input logic [CNT_W-1:0]  count_o,
  input logic              update_o,
  input logic              upd_evt,
  input logic [CNT_W-1:0]  arr_act,
  input logic [PSC_W-1:0]  psc_cnt
);
  logic force_wr, reload_wr;
  assign force_wr  = reg_we && (reg_addr == 2'd0) && reg_wdata[CTL_FORCE];
  assign reload_wr = reg_we && (reg_addr == 2'd2);

  AST_FORCE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    force_wr |=> update_o); // R8

  AST_FORCE_PSC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    force_wr |=> (psc_cnt == '0)); // R9

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !reg_we) |=> ($stable(count_o) && !update_o)); // R10

  AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.preload && !upd_evt) |=> $stable(arr_act)); // R5

  AST_DIRECT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.preload && reload_wr) |=> (arr_act == $past(reg_wdata[CNT_W-1:0]))); // R6

  AST_UP_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (update_o && !ctrl.down && $stable(ctrl.down)) |-> (count_o == '0)); // R4

  AST_DOWN_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (update_o && ctrl.down && $stable(ctrl.down)) |-> (count_o == arr_act)); // R4
endmodule

bind prescaled_reload_timer prt_checker #(
  .CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)
) u_prt_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .ctrl      (ctrl_q),
  .count_o   (count_o),
  .update_o  (update_o),
  .upd_evt   (upd_evt),
  .arr_act   (arr_act),
  .psc_cnt   (psc_cnt)
);

// File: tb/prescaled_reload_timer_bench.sv
`timescale 1ns/1ps
module prescaled_reload_timer_bench;
  localparam int CNT_W  = 16;
  localparam int PSC_W  = 16;
  localparam int DATA_W = 16;

  // control bits: 0 enable, 1 down, 2 preload, 3 force update
  localparam logic [15:0] C_EN = 16'h1, C_DN = 16'h2, C_PRE = 16'h4, C_UG = 16'h8;

  // vector: [39:32] prescaler, [31:24] reload, [23:16] down, [15:0] expected period
  localparam int NV = 7;
  localparam logic [39:0] VEC [NV] = '{
    {8'd0, 8'd0, 8'd0, 16'd1},
    {8'd0, 8'd4, 8'd0, 16'd5},
    {8'd2, 8'd3, 8'd0, 16'd12},
    {8'd1, 8'd0, 8'd0, 16'd2},
    {8'd3, 8'd5, 8'd1, 16'd24},
    {8'd0, 8'd7, 8'd1, 16'd8},
    {8'd4, 8'd2, 8'd1, 16'd15}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_we;
  logic [1:0]        reg_addr;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic [CNT_W-1:0]  count_o;
  logic              update_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  prescaled_reload_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_prescaled_reload_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .count_o   (count_o),
    .update_o  (update_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic wait_upd(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!update_o && n < 4000);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 update", update_o, 0);
    for (int a = 0; a < 4; a++) rd_chk(2'(a), 16'd0, "R1 read");

    // table of settings: period and wrap value
    for (int i = 0; i < NV; i++) begin
      logic [7:0] p, r;
      logic dn;
      logic [15:0] per, wv;
      p = VEC[i][39:32]; r = VEC[i][31:24]; dn = VEC[i][16]; per = VEC[i][15:0];
      wv = dn ? 16'(r) : 16'd0;
      wr(2'd0, 16'd0);
      wr(2'd1, 16'(p));
      wr(2'd2, 16'(r));
      wr(2'd0, C_EN | (dn ? C_DN : 16'd0) | C_UG);
      chk("R8 forced pulse", update_o, 1);
      chk("R8 reinit count", count_o, wv);
      wait_upd(n);
      chk("R3 period", n, per);
      chk("R4 wrap value", count_o, wv);
      wait_upd(n);
      chk("R3 second period", n, per);
    end

    // R2 readback, force bit reads 0
    wr(2'd0, 16'd0);
    wr(2'd1, 16'h00A5);
    rd_chk(2'd1, 16'h00A5, "R2 prescaler read");
    wr(2'd2, 16'h0003);
    rd_chk(2'd2, 16'h0003, "R2 reload read");
    wr(2'd0, C_PRE | C_UG);
    rd_chk(2'd0, 16'h0004, "R2 control read, force bit 0");

    // R8 forced update while disabled; R10 hold and count load
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd3);
    wr(2'd0, C_UG);
    chk("R8 disabled forced pulse", update_o, 1);
    chk("R8 disabled count 0", count_o, 0);
    @(negedge clk);
    chk("R8 single pulse", update_o, 0);
    wr(2'd3, 16'd5);
    rd_chk(2'd3, 16'd5, "R10 count write read");
    repeat (4) @(negedge clk);
    chk("R10 held count", count_o, 5);
    chk("R10 no update", update_o, 0);
    wr(2'd0, C_EN);
    wait_upd(n);
    chk("R4 wrap from above reload", n, 1);
    chk("R4 wrap to zero", count_o, 0);
    wr(2'd0, 16'd0);
    wr(2'd0, C_DN | C_UG);
    chk("R8 down reinit to reload", count_o, 3);
    chk("R8 down pulse", update_o, 1);

    // R9 forced update mid prescale restarts prescaler
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd2);
    wr(2'd0, C_EN | C_UG);
    wait_upd(n);
    chk("R3 period 12", n, 12);
    @(negedge clk);
    wr(2'd0, C_EN | C_UG);
    chk("R9 forced pulse", update_o, 1);
    wait_upd(n);
    chk("R9 full period after force", n, 12);

    // R6 direct reload write
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd9);
    wr(2'd0, C_EN | C_UG);
    wait_upd(n);
    chk("R3 period 10", n, 10);
    wr(2'd2, 16'd3);
    wait_upd(n);
    chk("R6 immediate reload", n, 2);
    wait_upd(n);
    chk("R6 new period", n, 4);

    // R5 preloaded reload write
    wr(2'd0, 16'd0);
    wr(2'd2, 16'd9);
    wr(2'd0, C_EN | C_PRE | C_UG);
    wait_upd(n);
    chk("R5 period 10", n, 10);
    wr(2'd2, 16'd3);
    wait_upd(n);
    chk("R5 old reload kept", n, 8);
    wait_upd(n);
    chk("R5 new reload after update", n, 4);
    rd_chk(2'd2, 16'd3, "R2 reload read back");

    // R7 prescaler change waits for update
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd4);
    wr(2'd0, C_EN | C_UG);
    wait_upd(n);
    chk("R3 period 5", n, 5);
    wr(2'd1, 16'd2);
    wait_upd(n);
    chk("R7 old prescaler kept", n, 3);
    wait_upd(n);
    chk("R7 new prescaler after update", n, 15);

    finish_run();
  end
endmodule